// File: doc/BRIEF.md
# Reduced-Subset Integer Execute Unit

This block is the execute stage for a small integer instruction subset. It receives the decoded fields of one instruction (primary opcode, function code, 5-bit shift count and 16-bit immediate) and the two values read from the register file. From these it produces one 32-bit result. Internally it turns the opcode and function code into an operation select. It widens the immediate with sign or zero fill, as the instruction requires. The shift count is widened with zeros. Two selectors then route the operands into a single arithmetic/logic core.

The unit is purely combinational. It has no clock, no reset and no state. The result settles in the same cycle as its inputs, so the surrounding pipeline places registers on either side of it. Arithmetic wraps modulo 2^32 and raises no flag. Any encoding outside the supported set yields zero, which the pipeline treats as a no-op.

Top module: `exec_subset_alu`

## Requirements
- R1: With op_code 0x00 and fn_code 0x20, result equals rs_val + rt_val as signed two's-complement arithmetic, wrapping modulo 2^32.
- R2: With op_code 0x00 and fn_code 0x22, result equals rs_val - rt_val, wrapping modulo 2^32.
- R3: With op_code 0x08, result equals rs_val plus imm16 sign-extended to 32 bits (bit 15 copied into bits 31..16), wrapping modulo 2^32.
- R4: With op_code 0x00 and fn_code 0x25, result equals the bitwise OR of rs_val and rt_val.
- R5: With op_code 0x0D, result equals rs_val ORed with imm16 zero-extended to 32 bits, so bits 31..16 of result equal those of rs_val.
- R6: With op_code 0x00 and fn_code 0x00, result equals rt_val shifted left by shamt (0..31) with zero fill. rs_val has no effect.
- R7: With op_code 0x00 and fn_code 0x02, result equals rt_val shifted right by shamt with zero fill. rs_val has no effect.
- R8: With op_code 0x00 and fn_code 0x03, result equals rt_val shifted right by shamt with every vacated bit equal to rt_val bit 31. rs_val has no effect.
- R9: Any op_code other than 0x00, 0x08 and 0x0D, and any fn_code under op_code 0x00 other than 0x00, 0x02, 0x03, 0x20, 0x22 and 0x25, gives result 0.
- R10: For op_code 0x08 and 0x0D, fn_code, shamt and rt_val have no effect on result. For the register add, sub and OR, shamt and imm16 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode; 0 marks register-register forms |
| fn_code | input | 6 | Function code, meaningful when op_code is 0 |
| shamt | input | 5 | Shift count for the shift forms |
| imm16 | input | 16 | Immediate field of the immediate forms |
| rs_val | input | 32 | First register read value |
| rt_val | input | 32 | Second register read value |
| result | output | 32 | Computed result, or 0 for unsupported encodings |

## Verification
The checker evaluates its properties whenever the inputs change. It assumes that every input is a known 0/1 value, and it skips any evaluation in which an input holds X or Z. The bench drives every field from zero at time zero and changes all fields together in one step. It samples the result a full nanosecond later, so the checker and the bench only see settled values. The vectors cover both signs of the immediate and of rt_val bit 31, and shift counts of 0, 1 and 31. They also place varying junk in the fields that each form must ignore.

// File: rtl/exec_subset_alu.sv
module exec_subset_alu #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5
) (
  input  logic [5:0]       op_code,
  input  logic [5:0]       fn_code,
  input  logic [SH_W-1:0]  shamt,
  input  logic [IMM_W-1:0] imm16,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  result
);
  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] FN_SLL   = 6'h00;
  localparam logic [5:0] FN_SRL   = 6'h02;
  localparam logic [5:0] FN_SRA   = 6'h03;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_OR    = 6'h25;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_OR, K_SLL, K_SRL, K_SRA
  } kind_e;

  kind_e             kind;
  logic              pick_imm;
  logic              pick_sh;
  logic              imm_signed;
  logic [XLEN-1:0]   imm_wide;
  logic [XLEN-1:0]   sh_wide;
  logic [XLEN-1:0]   opa;
  logic [XLEN-1:0]   opb;

  always_comb begin
    kind       = K_NOP;
    pick_imm   = 1'b0;
    pick_sh    = 1'b0;
    imm_signed = 1'b0;
    unique case (op_code)
      OPC_ADDI: begin kind = K_ADD; pick_imm = 1'b1; imm_signed = 1'b1; end
      OPC_ORI:  begin kind = K_OR;  pick_imm = 1'b1; end
      OPC_REG: begin
        case (fn_code)
          FN_ADD: kind = K_ADD;
          FN_SUB: kind = K_SUB;
          FN_OR:  kind = K_OR;
          FN_SLL: begin kind = K_SLL; pick_sh = 1'b1; end
          FN_SRL: begin kind = K_SRL; pick_sh = 1'b1; end
          FN_SRA: begin kind = K_SRA; pick_sh = 1'b1; end
          default: kind = K_NOP;
        endcase
      end
      default: kind = K_NOP;
    endcase
  end

  assign imm_wide = {{(XLEN-IMM_W){imm_signed & imm16[IMM_W-1]}}, imm16};
  assign sh_wide  = {{(XLEN-SH_W){1'b0}}, shamt};

  assign opa = pick_sh  ? sh_wide  : rs_val;
  assign opb = pick_imm ? imm_wide : rt_val;

  always_comb begin
    case (kind)
      K_ADD:   result = XLEN'($signed(opa) + $signed(opb));
      K_SUB:   result = XLEN'($signed(opa) - $signed(opb));
      K_OR:    result = opa | opb;
      K_SLL:   result = opb << opa;
      K_SRL:   result = opb >> opa;
      K_SRA:   result = XLEN'($signed(opb) >>> opa);
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/exec_subset_alu_chk.sv
module exec_subset_alu_chk (
  input logic [5:0]  op_code,
  input logic [5:0]  fn_code,
  input logic [4:0]  shamt,
  input logic [15:0] imm16,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] result
);
  logic known;
  logic is_reg;
  assign known  = !$isunknown({op_code, fn_code, shamt, imm16, rs_val, rt_val});
  assign is_reg = (op_code == 6'h00);

  always_comb begin
    if (known) begin
      if (is_reg && fn_code == 6'h20)
        p_add_sum_r1: assert (result - rt_val == rs_val);
      if (is_reg && fn_code == 6'h22)
        p_sub_diff_r2: assert (result + rt_val == rs_val);
      if (op_code == 6'h08)
        p_addi_sext_r3: assert (result - rs_val == {{16{imm16[15]}}, imm16});
      if (is_reg && fn_code == 6'h25)
        p_or_cover_r4: assert (((result & rs_val) == rs_val) && ((result & rt_val) == rt_val)
                               && ((result & ~(rs_val | rt_val)) == 32'h0));
      if (op_code == 6'h0D)
        p_ori_upper_r5: assert (result[31:16] == rs_val[31:16]);
      if (is_reg && fn_code == 6'h00)
        p_sll_lowzero_r6: assert ((result & ((32'h1 << shamt) - 32'h1)) == 32'h0);
      if (is_reg && fn_code == 6'h02)
        p_srl_roundtrip_r7: assert ((result << shamt) == ((rt_val >> shamt) << shamt));
      if (is_reg && fn_code == 6'h03)
        p_sra_signfill_r8: assert (result[31] == rt_val[31]);
      if (!(op_code inside {6'h00, 6'h08, 6'h0D}) ||
          (is_reg && !(fn_code inside {6'h00, 6'h02, 6'h03, 6'h20, 6'h22, 6'h25})))
        p_nop_zero_r9: assert (result == 32'h0);
    end
  end
endmodule

bind exec_subset_alu exec_subset_alu_chk u_chk (.*);

// File: tb/exec_subset_alu_tb.sv
module exec_subset_alu_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  op_code = '0;
  logic [5:0]  fn_code = '0;
  logic [4:0]  shamt   = '0;
  logic [15:0] imm16   = '0;
  logic [31:0] rs_val  = '0;
  logic [31:0] rt_val  = '0;
  logic [31:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  exec_subset_alu u_dut (.*);

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
                       input logic [15:0] im, input logic [31:0] a, input logic [31:0] b);
    op_code = op; fn_code = fn; shamt = sh; imm16 = im; rs_val = a; rt_val = b;
    #1;
  endtask

  task automatic expect_eq(input string req, input logic [31:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic t_idle;
    #1; expect_eq("R6 all-zero inputs", 32'h0);
  endtask

  task automatic t_add;
    apply(6'h00, 6'h20, 5'd7, 16'h1234, 32'd100, 32'hFFFF_FFFB); expect_eq("R1", 32'd95);
    apply(6'h00, 6'h20, 5'd0, 16'h0, 32'h7FFF_FFFF, 32'd1);      expect_eq("R1 wrap", 32'h8000_0000);
  endtask

  task automatic t_sub;
    apply(6'h00, 6'h22, 5'd3, 16'hFFFF, 32'd5, 32'd9);           expect_eq("R2", 32'hFFFF_FFFC);
    apply(6'h00, 6'h22, 5'd0, 16'h0, 32'h8000_0000, 32'd1);      expect_eq("R2 wrap", 32'h7FFF_FFFF);
  endtask

  task automatic t_addi;
    apply(6'h08, 6'h3F, 5'd31, 16'hFFFE, 32'd10, 32'hDEAD_BEEF); expect_eq("R3 neg", 32'd8);
    apply(6'h08, 6'h00, 5'd0, 16'h7FFF, 32'd1, 32'h0);           expect_eq("R3 pos", 32'h0000_8000);
  endtask

  task automatic t_or;
    apply(6'h00, 6'h25, 5'd9, 16'hAAAA, 32'hF0F0_0000, 32'h0000_0F0F); expect_eq("R4", 32'hF0F0_0F0F);
    apply(6'h0D, 6'h20, 5'd4, 16'h8001, 32'h1234_0000, 32'hFFFF_FFFF); expect_eq("R5 zext", 32'h1234_8001);
  endtask

  task automatic t_shift;
    apply(6'h00, 6'h00, 5'd4, 16'hFFFF, 32'hFFFF_FFFF, 32'h8000_0001); expect_eq("R6 sll", 32'h0000_0010);
    apply(6'h00, 6'h00, 5'd31, 16'h0, 32'h0, 32'h0000_0003);           expect_eq("R6 sll 31", 32'h8000_0000);
    apply(6'h00, 6'h02, 5'd1, 16'h0, 32'hFFFF_FFFF, 32'hF000_0000);    expect_eq("R7 srl", 32'h7800_0000);
    apply(6'h00, 6'h02, 5'd31, 16'h0, 32'h0, 32'h8000_0000);           expect_eq("R7 srl 31", 32'h1);
    apply(6'h00, 6'h03, 5'd4, 16'h0, 32'h0, 32'hF000_0000);            expect_eq("R8 sra neg", 32'hFF00_0000);
    apply(6'h00, 6'h03, 5'd4, 16'h0, 32'hFFFF_FFFF, 32'h7000_0000);    expect_eq("R8 sra pos", 32'h0700_0000);
    apply(6'h00, 6'h03, 5'd0, 16'h0, 32'h0, 32'h8000_0005);            expect_eq("R8 sra 0", 32'h8000_0005);
  endtask

  task automatic t_nop;
    apply(6'h23, 6'h20, 5'd1, 16'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); expect_eq("R9 opcode", 32'h0);
    apply(6'h00, 6'h24, 5'd1, 16'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); expect_eq("R9 funct", 32'h0);
    apply(6'h00, 6'h01, 5'd1, 16'h1, 32'h1, 32'h1);                 expect_eq("R9 funct 1", 32'h0);
  endtask

  task automatic t_ignore;
    apply(6'h08, 6'h22, 5'd17, 16'h0010, 32'd1, 32'h5555_5555); expect_eq("R10 addi", 32'd17);
    apply(6'h08, 6'h25, 5'd2,  16'h0010, 32'd1, 32'h0);          expect_eq("R10 addi", 32'd17);
    apply(6'h00, 6'h20, 5'd31, 16'hFFFF, 32'd2, 32'd3);          expect_eq("R10 add", 32'd5);
    apply(6'h00, 6'h25, 5'd31, 16'hFFFF, 32'h0, 32'h0);          expect_eq("R10 or", 32'h0);
  endtask

  initial begin
    t_idle; t_add; t_sub; t_addi; t_or; t_shift; t_nop; t_ignore;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: result=%h expected=completion", result);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule